// File: doc/BRIEF.md
# SPI Register Access Slave with Burst Transfers

This block lets an SPI host read and write a register file inside the chip. The host pulls the active-low chip select low and sends a 9-bit header on the serial input. The header holds a direction flag, then a 7-bit register address, then a burst flag. One or more data bytes follow. In single mode exactly one byte moves. In burst mode bytes keep moving and the address steps by one after each byte, until chip select rises. The link runs in SPI mode 0: the block samples on the rising serial clock edge and changes its serial output after the falling edge.

The block samples the serial pins with the system clock. The serial clock therefore has to be much slower than the system clock: each serial clock half period must be at least eight system clocks. On the chip side the block issues requests over a valid/ready port. A request holds `reg_req_valid` and its fields steady until `reg_req_ready` is seen high on a clock edge. The block never has more than one request in flight. A read is finished by a one-cycle `reg_rsp_valid` pulse that carries the data. The register file may stall through ready, or delay the response, by a few cycles. The read data must arrive before the first bit of its byte is due on the serial output. Reads are fetched ahead of time to allow for this, so a fetch has at least one serial clock period to complete.

Top module: `spi_reg_slave`

## Requirements
- R1: After chip select falls, the first sampled bit is the direction flag (0 = write, 1 = read). The next 7 bits are the register address, MSB first. The bit after that is the burst flag (0 = single, 1 = burst). Data bytes follow, MSB first. Every input bit is sampled on a rising serial clock edge.
- R2: A single-mode write issues exactly one write request, carrying the header address and the 8 data bits, after the eighth data bit. Any further bits in the same frame cause no request.
- R3: A single-mode read issues exactly one read request. The serial output presents the addressed byte MSB first, each bit changing after a falling serial clock edge. The first bit is valid before the first rising edge of the data phase.
- R4: A burst write writes each complete byte to the next address in turn, starting at the header address. The address wraps from 127 to 0.
- R5: A burst read returns the contents of the next address for each byte in turn, wrapping from 127 to 0. Each byte is fetched before its first bit is due.
- R6: A data byte that is only partly received when chip select rises produces no write request.
- R7: Chip select rising at any point ends the frame. The next frame is decoded from its header.
- R8: The serial output enable is low while chip select is high. While chip select is low and no read byte is being shifted out, the serial output drives 0.
- R9: A request holds its valid and its fields until accepted. No new request is issued while a request or a read response is outstanding.
- R10: After reset no request is pending and the serial output enable follows chip select (inactive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Output enable for the serial data pad |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted |
| reg_req_we | output | 1 | 1 = write request, 0 = read request |
| reg_req_addr | output | 7 | Register address |
| reg_req_wdata | output | 8 | Write data |
| reg_rsp_valid | input | 1 | Read response valid, one cycle |
| reg_rsp_data | input | 8 | Read response data |

## Verification
Every one of the 128 addresses is written and read back in single mode, so a misplaced header bit or a wrong flag polarity shows up as wrong data or a wrong address. Burst transfers start near the top of the address space, with the register port stalling, so a missing wrap-around or a fetch that comes too late sends bytes to the wrong register or returns stale data. Frames cut short in the header, in mid-byte and after the first single-mode byte catch a design that commits a partial byte, keeps writing past the single byte, or keeps stale header state into the next frame.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Frame decoding phase
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,  // collecting direction, address, burst flag
    PH_DATA = 2'd1,  // moving data bytes
    PH_DONE = 2'd2   // single transfer complete, ignore the rest
  } phase_e;

  localparam int unsigned DEF_ADDR_W = 7;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_SYNC   = 2;

endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_reg_frame.sv
module spi_reg_frame
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,  // at least 3
  parameter int unsigned DATA_W = DEF_DATA_W   // at least 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_bit,
  input  logic [DATA_W-1:0] rbuf,
  output logic              rd_pulse,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              load_pulse,
  output logic              sdo_bit
);

  localparam int unsigned HDR_LEN = ADDR_W + 2;
  localparam int unsigned MAXC    = (HDR_LEN > DATA_W) ? HDR_LEN : DATA_W;
  localparam int unsigned CNT_W   = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);

  phase_e              phase;
  logic [CNT_W-1:0]    cnt;
  logic                is_rd;
  logic                burst;
  logic [ADDR_W-2:0]   abuf;
  logic [ADDR_W-1:0]   addr;
  logic [ADDR_W-1:0]   fetch_addr;
  logic [DATA_W-2:0]   rx;
  logic [DATA_W-1:0]   tx;
  logic [ADDR_W-1:0]   hdr_addr;
  logic [DATA_W-1:0]   rx_full;

  // Address and byte as they stand once the current bit is shifted in
  assign hdr_addr = {abuf, sdi_bit};
  assign rx_full  = {rx, sdi_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_HDR;
      cnt        <= '0;
      is_rd      <= 1'b0;
      burst      <= 1'b0;
      abuf       <= '0;
      addr       <= '0;
      fetch_addr <= '0;
      rx         <= '0;
      tx         <= '0;
      sdo_bit    <= 1'b0;
      rd_pulse   <= 1'b0;
      rd_addr    <= '0;
      wr_pulse   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      load_pulse <= 1'b0;
    end else begin
      rd_pulse   <= 1'b0;
      wr_pulse   <= 1'b0;
      load_pulse <= 1'b0;
      if (!cs_act) begin
        // Deselected: abort whatever was in progress
        phase   <= PH_HDR;
        cnt     <= '0;
        sdo_bit <= 1'b0;
      end else begin
        if (sclk_rise) begin
          unique case (phase)
            PH_HDR: begin
              if (cnt == '0) begin
                is_rd <= sdi_bit;
                cnt   <= cnt + 1'b1;
              end else if (cnt < ADDR_LAST) begin
                abuf <= {abuf[ADDR_W-3:0], sdi_bit};
                cnt  <= cnt + 1'b1;
              end else if (cnt == ADDR_LAST) begin
                addr       <= hdr_addr;
                fetch_addr <= hdr_addr + ONE_A;
                cnt        <= cnt + 1'b1;
                if (is_rd) begin
                  // Fetch the first byte before the burst flag is even known
                  rd_pulse <= 1'b1;
                  rd_addr  <= hdr_addr;
                end
              end else begin
                burst <= sdi_bit;
                phase <= PH_DATA;
                cnt   <= '0;
              end
            end
            PH_DATA: begin
              rx <= {rx[DATA_W-3:0], sdi_bit};
              if (cnt == BYTE_LAST) begin
                cnt  <= '0;
                addr <= addr + ONE_A;
                if (!is_rd) begin
                  wr_pulse <= 1'b1;
                  wr_addr  <= addr;
                  wr_data  <= rx_full;
                end
                if (!burst) phase <= PH_DONE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (sclk_fall) begin
          if (phase == PH_DATA && is_rd) begin
            if (cnt == '0) begin
              // Byte boundary: present the fetched byte, prefetch the next
              load_pulse <= 1'b1;
              sdo_bit    <= rbuf[DATA_W-1];
              tx         <= {rbuf[DATA_W-2:0], 1'b0};
              if (burst) begin
                rd_pulse   <= 1'b1;
                rd_addr    <= fetch_addr;
                fetch_addr <= fetch_addr + ONE_A;
              end
            end else begin
              sdo_bit <= tx[DATA_W-1];
              tx      <= {tx[DATA_W-2:0], 1'b0};
            end
          end else begin
            sdo_bit <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_pulse,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] rbuf,
  output logic              rbuf_ok
);

  logic rd_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      rd_wait   <= 1'b0;
      rbuf      <= '0;
      rbuf_ok   <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        if (!req_we) rd_wait <= 1'b1;
      end
      if (rsp_valid && rd_wait) begin
        rbuf    <= rsp_data;
        rbuf_ok <= 1'b1;
        rd_wait <= 1'b0;
      end
      if (rd_pulse || wr_pulse) begin
        req_valid <= 1'b1;
        req_we    <= wr_pulse;
        req_addr  <= wr_pulse ? wr_addr : rd_addr;
        req_wdata <= wr_data;
        if (rd_pulse) rbuf_ok <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SYNC_N = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              reg_req_valid,
  input  logic              reg_req_ready,
  output logic              reg_req_we,
  output logic [ADDR_W-1:0] reg_req_addr,
  output logic [DATA_W-1:0] reg_req_wdata,
  input  logic              reg_rsp_valid,
  input  logic [DATA_W-1:0] reg_rsp_data
);

  // Pin order inside the synchronizer bundle
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_SDI  = 1;
  localparam int unsigned PIN_CS   = 2;
  localparam logic [2:0]  PIN_RST  = 3'b100;

  logic [2:0]        pins_s;
  logic              sclk_q;
  logic              cs_act;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              rd_pulse;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_pulse;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              load_pulse;
  logic              sdo_bit;
  logic [DATA_W-1:0] rbuf;
  logic              rbuf_ok;

  spi_reg_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sdi, spi_sclk}),
    .q     (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= pins_s[PIN_SCLK];
  end

  assign cs_act    = !pins_s[PIN_CS];
  assign sclk_rise =  pins_s[PIN_SCLK] && !sclk_q;
  assign sclk_fall = !pins_s[PIN_SCLK] &&  sclk_q;

  spi_reg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sdi_bit    (pins_s[PIN_SDI]),
    .rbuf       (rbuf),
    .rd_pulse   (rd_pulse),
    .rd_addr    (rd_addr),
    .wr_pulse   (wr_pulse),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .load_pulse (load_pulse),
    .sdo_bit    (sdo_bit)
  );

  spi_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pulse  (rd_pulse),
    .rd_addr   (rd_addr),
    .wr_pulse  (wr_pulse),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .req_valid (reg_req_valid),
    .req_ready (reg_req_ready),
    .req_we    (reg_req_we),
    .req_addr  (reg_req_addr),
    .req_wdata (reg_req_wdata),
    .rsp_valid (reg_rsp_valid),
    .rsp_data  (reg_rsp_data),
    .rbuf      (rbuf),
    .rbuf_ok   (rbuf_ok)
  );

  assign spi_sdo    = sdo_bit;
  assign spi_sdo_oe = !spi_cs_n;

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sclk_fall,
  input logic              spi_sdo,
  input logic              rd_pulse,
  input logic              wr_pulse,
  input logic              load_pulse,
  input logic              rbuf_ok,
  input logic              reg_req_valid,
  input logic              reg_req_ready,
  input logic              reg_req_we,
  input logic [ADDR_W-1:0] reg_req_addr,
  input logic [DATA_W-1:0] reg_req_wdata,
  input logic              reg_rsp_valid
);

  // Independent tracking of an accepted read that has not been answered
  logic rd_out;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_out <= 1'b0;
    else if (reg_req_valid && reg_req_ready && !reg_req_we) rd_out <= 1'b1;
    else if (reg_rsp_valid) rd_out <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && !reg_req_ready |=>
      reg_req_valid && $stable(reg_req_we) && $stable(reg_req_addr) && $stable(reg_req_wdata)); // R9

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse || wr_pulse) |-> !reg_req_valid && !rd_out); // R9

  AST_FETCH_IN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> rbuf_ok); // R5

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act && !sclk_fall |=> !cs_act || $stable(spi_sdo)); // R3

  AST_REQ_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_req_valid) |-> $past(cs_act, 2)); // R7

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_act        (cs_act),
  .sclk_fall     (sclk_fall),
  .spi_sdo       (spi_sdo),
  .rd_pulse      (rd_pulse),
  .wr_pulse      (wr_pulse),
  .load_pulse    (load_pulse),
  .rbuf_ok       (rbuf_ok),
  .reg_req_valid (reg_req_valid),
  .reg_req_ready (reg_req_ready),
  .reg_req_we    (reg_req_we),
  .reg_req_addr  (reg_req_addr),
  .reg_req_wdata (reg_req_wdata),
  .reg_rsp_valid (reg_rsp_valid)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;

  localparam int HALF = 8;  // system clocks per serial clock half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_sdi = 1'b0;
  logic       spi_sdo;
  logic       spi_sdo_oe;
  logic       reg_req_valid;
  logic       reg_req_ready;
  logic       reg_req_we;
  logic [6:0] reg_req_addr;
  logic [7:0] reg_req_wdata;
  logic       reg_rsp_valid;
  logic [7:0] reg_rsp_data;

  always #4 clk = ~clk;

  spi_reg_slave u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_sclk      (spi_sclk),
    .spi_cs_n      (spi_cs_n),
    .spi_sdi       (spi_sdi),
    .spi_sdo       (spi_sdo),
    .spi_sdo_oe    (spi_sdo_oe),
    .reg_req_valid (reg_req_valid),
    .reg_req_ready (reg_req_ready),
    .reg_req_we    (reg_req_we),
    .reg_req_addr  (reg_req_addr),
    .reg_req_wdata (reg_req_wdata),
    .reg_rsp_valid (reg_rsp_valid),
    .reg_rsp_data  (reg_rsp_data)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] wr_val(input int a);
    return 8'(a * 37 + 11);
  endfunction

  // Register file model with optional stalls
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  int         wr_cnt, rd_cnt, cyc;
  logic       stall_en = 1'b0;

  assign reg_req_ready = !stall_en || (cyc[1:0] == 2'b11);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
      wr_cnt        <= 0;
      rd_cnt        <= 0;
      cyc           <= 0;
      reg_rsp_valid <= 1'b0;
      reg_rsp_data  <= '0;
    end else begin
      cyc           <= cyc + 1;
      reg_rsp_valid <= 1'b0;
      if (reg_req_valid && reg_req_ready) begin
        if (reg_req_we) begin
          mem[reg_req_addr] <= reg_req_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          reg_rsp_valid <= 1'b1;
          reg_rsp_data  <= mem[reg_req_addr];
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  int errors = 0;
  int checks = 0;
  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  logic       oe_drop;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic half_per();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clk_bit(input logic v, output logic s);
    spi_sdi = v;
    half_per();
    s = spi_sdo;
    if (!spi_sdo_oe) oe_drop = 1'b1;
    spi_sclk = 1'b1;
    half_per();
    spi_sclk = 1'b0;
  endtask

  // One frame: hdr_bits of the 9-bit header (direction, address MSB first,
  // burst flag), then nbits data bits from tx_b, MSB first.
  task automatic run_frame(input logic rd, input logic [6:0] a, input logic bst,
                           input int hdr_bits, input int nbits);
    logic [8:0] hdr;
    logic       s;
    hdr = {rd, a, bst};
    oe_drop = 1'b0;
    spi_cs_n = 1'b0;
    half_per();
    for (int i = 0; i < hdr_bits; i++) clk_bit(hdr[8-i], s);
    for (int i = 0; i < nbits; i++) begin
      clk_bit(tx_b[i/8][7-(i%8)], s);
      rx_b[i/8][7-(i%8)] = s;
    end
    half_per();
    spi_cs_n = 1'b1;
    half_per();
    half_per();
  endtask

  task automatic mem_match(input string req, input int a);
    chk(mem[a] == exp_mem[a], req, mem[a], exp_mem[a]);
  endtask

  initial begin
    int w0, r0;
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(reg_req_valid == 1'b0, "R10 no request in reset", reg_req_valid, 0);
    chk(spi_sdo_oe == 1'b0, "R10 sdo_oe in reset", spi_sdo_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(reg_req_valid == 1'b0, "R10 no request after reset", reg_req_valid, 0);
    chk(spi_sdo_oe == 1'b0, "R8 sdo_oe with cs high", spi_sdo_oe, 0);

    // R1, R2: single writes to every address
    for (int a = 0; a < 128; a++) begin
      w0 = wr_cnt;
      tx_b[0] = wr_val(a);
      run_frame(1'b0, 7'(a), 1'b0, 9, 8);
      exp_mem[a] = wr_val(a);
      mem_match("R1 R2 single write data", a);
      chk(wr_cnt == w0 + 1, "R2 single write count", wr_cnt - w0, 1);
      if (a == 0) begin
        chk(rx_b[0] == 8'h00, "R8 sdo zero during write", rx_b[0], 0);
        chk(!oe_drop, "R8 sdo_oe during frame", oe_drop, 0);
      end
    end
    chk(spi_sdo_oe == 1'b0, "R8 sdo_oe after frame", spi_sdo_oe, 0);

    // R3: single reads of every address
    for (int a = 0; a < 128; a++) begin
      r0 = rd_cnt;
      tx_b[0] = 8'hFF;
      run_frame(1'b1, 7'(a), 1'b0, 9, 8);
      chk(rx_b[0] == exp_mem[a], "R3 single read data", rx_b[0], exp_mem[a]);
      chk(rd_cnt == r0 + 1, "R3 single read count", rd_cnt - r0, 1);
    end

    // R2: extra byte in single mode is ignored
    w0 = wr_cnt;
    tx_b[0] = 8'h3C; tx_b[1] = 8'hC3;
    run_frame(1'b0, 7'd40, 1'b0, 9, 16);
    exp_mem[40] = 8'h3C;
    mem_match("R2 single first byte", 40);
    mem_match("R2 single second byte ignored", 41);
    chk(wr_cnt == w0 + 1, "R2 single extra byte count", wr_cnt - w0, 1);

    // R4, R9: burst write across the wrap with stalls
    stall_en = 1'b1;
    w0 = wr_cnt;
    for (int i = 0; i < 5; i++) tx_b[i] = 8'(8'hA0 + i * 3);
    run_frame(1'b0, 7'd125, 1'b1, 9, 40);
    for (int i = 0; i < 5; i++) begin
      exp_mem[(125 + i) % 128] = 8'(8'hA0 + i * 3);
      mem_match("R4 R9 burst write wrap", (125 + i) % 128);
    end
    mem_match("R4 burst write stops", 2);
    chk(wr_cnt == w0 + 5, "R4 burst write count", wr_cnt - w0, 5);

    // R5: burst read across the wrap with stalls
    for (int i = 0; i < 4; i++) tx_b[i] = 8'h00;
    run_frame(1'b1, 7'd126, 1'b1, 9, 32);
    for (int i = 0; i < 4; i++)
      chk(rx_b[i] == exp_mem[(126 + i) % 128], "R5 burst read wrap",
          rx_b[i], exp_mem[(126 + i) % 128]);
    stall_en = 1'b0;

    // R6: partial byte in single mode
    w0 = wr_cnt;
    tx_b[0] = 8'hE7;
    run_frame(1'b0, 7'd60, 1'b0, 9, 5);
    mem_match("R6 partial single byte", 60);
    chk(wr_cnt == w0, "R6 partial single count", wr_cnt - w0, 0);

    // R6: burst ending in a partial byte
    w0 = wr_cnt;
    tx_b[0] = 8'h11; tx_b[1] = 8'h22; tx_b[2] = 8'h33;
    run_frame(1'b0, 7'd10, 1'b1, 9, 19);
    exp_mem[10] = 8'h11; exp_mem[11] = 8'h22;
    mem_match("R6 burst full byte", 10);
    mem_match("R6 burst full byte", 11);
    mem_match("R6 burst partial byte", 12);
    chk(wr_cnt == w0 + 2, "R6 burst partial count", wr_cnt - w0, 2);

    // R7: abort inside the header, then a clean frame
    w0 = wr_cnt; r0 = rd_cnt;
    run_frame(1'b0, 7'd77, 1'b0, 4, 0);
    chk(wr_cnt == w0 && rd_cnt == r0, "R7 header abort no request",
        (wr_cnt - w0) + (rd_cnt - r0), 0);
    run_frame(1'b1, 7'd77, 1'b0, 9, 8);
    chk(rx_b[0] == exp_mem[77], "R7 frame after abort", rx_b[0], exp_mem[77]);

    // R7: abort in the middle of a read byte, then a write
    run_frame(1'b1, 7'd90, 1'b1, 9, 3);
    tx_b[0] = 8'h5C;
    run_frame(1'b0, 7'd91, 1'b0, 9, 8);
    exp_mem[91] = 8'h5C;
    mem_match("R7 write after read abort", 91);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule